// File: doc/BRIEF.md
# Interrupt Source ID Aggregator

This block collects interrupt requests from five neighbours (two input converters, two output converters and a digital I/O unit) into one 8-bit identification word and a single host interrupt line. Each converter request is caught on its rising edge and stays pending until the host reads that source's own clear offset. The digital I/O source is not latched: its ID bit follows the live OR of the I/O unit's pending flags and drops when those flags drop.

The host reaches the ID word through a byte-wide register port. Offset 0x0F normally shows a converter status byte that comes from outside the block. A control byte written to 0x0F is kept in a shadow register. While bit 5 of that shadow is set, reads of 0x0F return the ID word instead. The shadow byte is also driven out, so the converter logic can use its other bits. A host service routine sets the select bit, reads the ID word, reads the clear offset of each converter bit it finds set, and then clears the select bit.

Top module: `irq_id_agg`

## Requirements
- R1: After reset, every captured converter bit and the whole control shadow are zero. With no digital I/O flag pending, `irq` is low.
- R2: A 0-to-1 transition on a converter request sets its ID bit one clock later. The bit stays set whether the request stays high or falls, and a request held high does not set the bit again once it has been cleared.
- R3: A host read (bus_rd high at the clock edge) clears exactly one converter bit. Offset 0x1 clears ID bit 0 (input converter 1), 0x5 clears bit 1 (input converter 2), 0x9 clears bit 2 (output converter 1) and 0xD clears bit 4 (output converter 2). Every other bit keeps its value.
- R4: If a new rising edge arrives in the same cycle as the clear read for that source, the ID bit stays set.
- R5: ID bit 3 equals the OR of all digital I/O pending flags in the same cycle. No host read clears it.
- R6: While control bit 5 is set, a read of offset 0x0F returns the ID word, with bits 7 to 5 always zero.
- R7: While control bit 5 is clear, offset 0x0F returns `ext_rdata`. Every offset other than 0x0F always returns `ext_rdata`.
- R8: `irq` is high exactly when at least one of ID bits 0 to 4 is set.
- R9: A write to 0x0F loads all eight bits of the control shadow, which appears on `ctrl_byte` one clock later. Writes to any other offset leave the shadow unchanged.
- R10: A write to a clear offset does not clear the converter bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Host register offset |
| bus_rd | input | 1 | Host read strobe, one cycle per read |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| ext_rdata | input | 8 | Read data from the surrounding register file (status view) |
| cnv_req | input | 4 | Converter requests: [0] in 1, [1] in 2, [2] out 1, [3] out 2 |
| dio_pend | input | DIO_W | Digital I/O pending flags |
| bus_rdata | output | 8 | Host read data |
| irq | output | 1 | Combined interrupt to the host |
| ctrl_byte | output | 8 | Shadowed control byte |

## Verification
The bench goes after the corners where a pending bit could be lost or kept by mistake. A clear read that lands in the same cycle as a fresh edge would drop that edge if the clear took priority. A request held high after its clear would cause an interrupt storm if the design captured levels instead of edges. A wrong offset-to-bit mapping would clear a neighbour's pending bit. It also checks that the ID view appears only under the select bit and never leaks onto other offsets, that write strobes to clear offsets do nothing, and that the digital I/O bit follows its flags whatever the host reads. A cycle-by-cycle model runs under random traffic next to the directed cases.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NSRC    = 4;
  localparam int BYTE_W  = 8;
  localparam int DIO_POS = 3;
  localparam int ID_TOP  = 4;

  // ID bit position of converter source s
  function automatic int unsigned src_bit(input int unsigned s);
    case (s)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 4;
    endcase
  endfunction

  // host offset whose read clears converter source s
  function automatic int unsigned clr_offset(input int unsigned s);
    return 4 * s + 1;
  endfunction
endpackage

// File: rtl/edge_capture.sv
module edge_capture #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] edge_o,
  output logic [N-1:0] hold_o
);
  logic [N-1:0] req_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign edge_o[i] = req[i] & ~req_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i]  <= 1'b0;
        hold_o[i] <= 1'b0;
      end else begin
        req_q[i] <= req[i];
        if (edge_o[i])
          hold_o[i] <= 1'b1;
        else if (clr[i])
          hold_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clr_decode.sv
module clr_decode
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N      = NSRC
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  output logic [N-1:0]      clr_hit
);
  for (genvar i = 0; i < N; i++) begin : g_hit
    localparam int unsigned OFF = clr_offset(i);
    assign clr_hit[i] = bus_rd && (bus_addr == ADDR_W'(OFF));
  end
endmodule

// File: rtl/id_compose.sv
module id_compose
  import irqagg_pkg::*;
#(
  parameter int N     = NSRC,
  parameter int DIO_W = 24
) (
  input  logic [N-1:0]      hold,
  input  logic [DIO_W-1:0]  dio_pend,
  output logic [BYTE_W-1:0] id_word,
  output logic              irq
);
  always_comb begin
    id_word          = '0;
    id_word[DIO_POS] = |dio_pend;
    for (int s = 0; s < N; s++)
      id_word[src_bit(s)] = hold[s];
  end

  assign irq = |id_word[ID_TOP:0];
endmodule

// File: rtl/ctrl_shadow.sv
module ctrl_shadow
  import irqagg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFF = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] ctrl_q
);
  logic wr_hit;
  assign wr_hit = bus_wr && (bus_addr == ADDR_W'(CTRL_OFF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_hit)
      ctrl_q <= bus_wdata;
  end
endmodule

// File: rtl/irq_id_agg.sv
module irq_id_agg
  import irqagg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIO_W    = 24,
  parameter int CTRL_OFF = 15,
  parameter int SEL_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] ext_rdata,
  input  logic [NSRC-1:0]   cnv_req,
  input  logic [DIO_W-1:0]  dio_pend,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic [BYTE_W-1:0] ctrl_byte
);
  logic [NSRC-1:0]   cap_edge;
  logic [NSRC-1:0]   clr_hit;
  logic [NSRC-1:0]   cap_hold;
  logic [BYTE_W-1:0] id_word;
  logic              id_view;

  clr_decode #(.ADDR_W(ADDR_W), .N(NSRC)) u_dec (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .clr_hit(clr_hit)
  );

  edge_capture #(.N(NSRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .req(cnv_req), .clr(clr_hit),
    .edge_o(cap_edge), .hold_o(cap_hold)
  );

  id_compose #(.N(NSRC), .DIO_W(DIO_W)) u_id (
    .hold(cap_hold), .dio_pend(dio_pend), .id_word(id_word), .irq(irq)
  );

  ctrl_shadow #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_byte)
  );

  assign id_view   = ctrl_byte[SEL_BIT] && (bus_addr == ADDR_W'(CTRL_OFF));
  assign bus_rdata = id_view ? id_word : ext_rdata;
endmodule

// File: rtl/irq_id_chk.sv
module irq_id_chk
  import irqagg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIO_W    = 24,
  parameter int CTRL_OFF = 15,
  parameter int SEL_BIT  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   edge_v,
  input logic [NSRC-1:0]   clr_v,
  input logic [BYTE_W-1:0] id_v,
  input logic [BYTE_W-1:0] rdata,
  input logic [BYTE_W-1:0] ctrl,
  input logic [ADDR_W-1:0] addr,
  input logic [DIO_W-1:0]  dio,
  input logic              irq
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int unsigned P = src_bit(s);

    // R2
    cap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_v[s] |=> id_v[P]);

    // R3
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[s] && !edge_v[s]) |=> !id_v[P]);

    // R4
    clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[s] && edge_v[s]) |=> id_v[P]);
  end

  // R5
  dio_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_v[DIO_POS] == (|dio));

  // R6
  view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[SEL_BIT] && addr == ADDR_W'(CTRL_OFF)) |-> rdata == id_v);

  // R6
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_v[BYTE_W-1:ID_TOP+1] == '0);

  // R8
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|id_v[ID_TOP:0]));
endmodule

bind irq_id_agg irq_id_chk #(
  .ADDR_W(ADDR_W), .DIO_W(DIO_W), .CTRL_OFF(CTRL_OFF), .SEL_BIT(SEL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_v(cap_edge), .clr_v(clr_hit),
  .id_v(id_word), .rdata(bus_rdata), .ctrl(ctrl_byte), .addr(bus_addr),
  .dio(dio_pend), .irq(irq)
);

// File: tb/sim_irq_id_agg.sv
`timescale 1ns/1ps
module sim_irq_id_agg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [7:0]  bus_wdata = 0, ext_rdata = 8'hA5;
  logic [3:0]  cnv_req = 0;
  logic [23:0] dio_pend = 0;
  logic [7:0]  bus_rdata, ctrl_byte;
  logic        irq;

  always #2.5 clk = ~clk;

  irq_id_agg u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .ext_rdata(ext_rdata),
    .cnv_req(cnv_req), .dio_pend(dio_pend), .bus_rdata(bus_rdata),
    .irq(irq), .ctrl_byte(ctrl_byte)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit m_held[4];
  bit m_prev[4];
  int m_ctrl;
  int clr_tab[4] = '{1, 5, 9, 13};
  int pos_tab[4] = '{0, 1, 2, 4};

  function automatic int model_id();
    int v = 0;
    for (int s = 0; s < 4; s++) if (m_held[s]) v += (1 << pos_tab[s]);
    if (dio_pend != 0) v += 8;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) begin m_held[s] = 0; m_prev[s] = 0; end
      m_ctrl = 0;
    end else begin
      for (int s = 0; s < 4; s++) begin
        if (cnv_req[s] && !m_prev[s]) m_held[s] = 1;
        else if (bus_rd && bus_addr == clr_tab[s]) m_held[s] = 0;
        m_prev[s] = cnv_req[s];
      end
      if (bus_wr && bus_addr == 15) m_ctrl = bus_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_rd;
      exp_rd = (bus_addr == 15 && m_ctrl[5]) ? model_id() : ext_rdata;
      check(bus_rdata == exp_rd, "R6 R7 rdata", bus_rdata, exp_rd);
      check(irq == ((model_id() & 8'h1F) != 0), "R8 irq", irq, (model_id() & 8'h1F) != 0);
      check(ctrl_byte == m_ctrl, "R9 ctrl", ctrl_byte, m_ctrl);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(); bus_rd = 0; bus_wr = 0; endtask

  task automatic wr(input int a, input int d);
    bus_addr = a[3:0]; bus_wdata = d[7:0]; bus_wr = 1; bus_rd = 0; tick(); idle();
  endtask
  task automatic rd(input int a);
    bus_addr = a[3:0]; bus_rd = 1; bus_wr = 0; tick(); idle();
  endtask
  task automatic peek(input int a, input int exp, input string tag);
    bus_addr = a[3:0]; bus_rd = 0;
    @(negedge clk); #0.1;
    check(bus_rdata == exp[7:0], tag, bus_rdata, exp);
    tick();
  endtask
  task automatic pulse(input int s);
    cnv_req[s] = 1; tick(); cnv_req[s] = 0; tick();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1: reset state
    @(negedge clk); #0.1;
    check(ctrl_byte == 0, "R1 ctrl reset", ctrl_byte, 0);
    check(irq == 0, "R1 irq reset", irq, 0);
    tick();
    peek(15, 8'hA5, "R1 R7 status view after reset");
    // R9: control write, foreign write ignored
    wr(15, 8'h20);
    wr(3, 8'hFF);
    @(negedge clk); #0.1;
    check(ctrl_byte == 8'h20, "R9 ctrl shadow", ctrl_byte, 8'h20);
    tick();
    peek(15, 8'h00, "R6 id empty");
    // R2: capture, hold after fall
    pulse(0);
    peek(15, 8'h01, "R2 capture in1");
    @(negedge clk); #0.1; check(irq == 1, "R8 irq set", irq, 1); tick();
    peek(4, 8'hA5, "R7 other offset");
    // R3: clear
    rd(1);
    peek(15, 8'h00, "R3 clear in1");
    // all four then selective clears
    cnv_req = 4'hF; tick(); cnv_req = 0; tick();
    peek(15, 8'h17, "R2 all set");
    rd(9);
    peek(15, 8'h13, "R3 clear out1 only");
    rd(13);
    peek(15, 8'h03, "R3 clear out2 only");
    rd(5);
    peek(15, 8'h01, "R3 clear in2 only");
    rd(1);
    // R10: write to clear offset
    pulse(1);
    wr(5, 8'h00);
    peek(15, 8'h02, "R10 write does not clear");
    rd(5);
    // R2: level held across clear does not retrigger
    cnv_req[2] = 1; tick();
    rd(9);
    peek(15, 8'h00, "R2 level no retrigger");
    cnv_req[2] = 0; tick();
    // R4: edge coincident with clear
    pulse(3);
    cnv_req[3] = 1; bus_addr = 13; bus_rd = 1; tick(); idle();
    peek(15, 8'h10, "R4 edge beats clear");
    cnv_req[3] = 0; rd(13);
    // R5: dio live bit, not read-clearable
    dio_pend = 24'h020000; tick();
    rd(1); rd(5); rd(9); rd(13);
    peek(15, 8'h08, "R5 dio live");
    dio_pend = 0; tick();
    peek(15, 8'h00, "R5 dio drops");
    // R7: select off
    pulse(0);
    wr(15, 8'h00);
    ext_rdata = 8'h3C;
    peek(15, 8'h3C, "R7 select off");
    // random traffic, monitor compares
    for (int i = 0; i < 400; i++) begin
      int a;
      a = $urandom_range(0, 15);
      cnv_req = 4'($urandom);
      bus_addr = a[3:0];
      bus_rd = ($urandom_range(0, 2) == 0);
      bus_wr = !bus_rd && ($urandom_range(0, 5) == 0);
      bus_wdata = 8'($urandom);
      ext_rdata = 8'($urandom);
      dio_pend = ($urandom_range(0, 3) == 0) ? 24'($urandom) : 24'h0;
      tick();
    end
    idle();
    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule